// File: doc/BRIEF.md
# Byte Rotate and Shift Unit

This block is the bit-manipulation datapath of a small 8-bit processor core. Each cycle it can accept one byte, one incoming carry bit and a 3-bit operation code. It moves the bits of the byte one place left or right. The operation code chooses what fills the vacated end and which bit leaves as the new carry. It also builds a status byte that describes the result.

The result, the status byte and an illegal-operation marker are captured in one output register stage. They appear together with a valid strobe on the clock after the input strobe. The surrounding core does the opcode decode and supplies the operand from its register file or from memory. It then writes back the result and the status byte. When no new operation arrives, the output stage keeps its last contents.

Top module: `byte_shift_unit`

## Requirements
- R1: Code 000 rotates circularly to the left. Result bit 0 receives the old bit 7, and the carry flag receives the old bit 7.
- R2: Code 001 rotates circularly to the right. Result bit 7 receives the old bit 0, and the carry flag receives the old bit 0.
- R3: Code 010 rotates left through the carry. Result bit 0 receives carry_in, and the carry flag receives the old bit 7.
- R4: Code 011 rotates right through the carry. Result bit 7 receives carry_in, and the carry flag receives the old bit 0.
- R5: Code 100 shifts left arithmetically. Result bit 0 becomes 0, and the carry flag receives the old bit 7.
- R6: Code 101 shifts right arithmetically. Result bit 7 keeps the old bit 7, and the carry flag receives the old bit 0.
- R7: Code 111 shifts right logically. Result bit 7 becomes 0, and the carry flag receives the old bit 0.
- R8: Status bit 7 (sign) equals result bit 7. Status bit 6 (zero) is 1 exactly when the result is 0x00.
- R9: Status bit 2 (parity) is 1 when the result holds an even number of ones, and 0 when it holds an odd number.
- R10: Status bit 4 (half carry), status bit 1 (subtract) and the unused status bits 5 and 3 are always 0. Status bit 0 is the carry flag.
- R11: Code 110 is illegal. It sets illegal_op to 1, passes the operand to the result unchanged and puts carry_in into the carry flag. Every other code gives illegal_op = 0.
- R12: result, flags and illegal_op change only on the clock after a cycle with in_valid = 1, and out_valid is in_valid delayed by one clock. With in_valid = 0, the outputs hold their values whatever the other inputs do.
- R13: While rst is 1 at a clock edge, out_valid, result, flags and illegal_op are cleared to 0, whatever in_valid does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand, carry and code are valid this cycle |
| operand | input | W (8) | Byte to rotate or shift |
| carry_in | input | 1 | Incoming carry flag |
| op_sel | input | 3 | Operation code |
| out_valid | output | 1 | Registered outputs carry a new result |
| result | output | W (8) | Rotated or shifted byte |
| flags | output | 8 | Status byte: S, Z, 0, H, 0, P, N, C from bit 7 down |
| illegal_op | output | 1 | Operation code 110 was issued |

## Verification
Every operation code, including the illegal one, is driven with all 256 operand values under both carry-in levels. This separates the through-carry rotates from the circular ones, because only the former depend on carry_in. It also separates the arithmetic right shift from the logical one, because their results differ exactly for operands with bit 7 set. The single-bit and all-ones operands that make up part of this sweep push the wrap-around bit into the zero, sign and parity flags. A hold scenario changes every data input while in_valid is low, so that a register stage loading without the strobe is caught. Reset is asserted together with an active strobe to show that reset wins.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int DW      = 8;
    localparam int OPW     = 3;
    localparam int FLAG_W  = 8;

    typedef enum logic [OPW-1:0] {
        OP_ROL_CIRC = 3'b000,
        OP_ROR_CIRC = 3'b001,
        OP_ROL_CARY = 3'b010,
        OP_ROR_CARY = 3'b011,
        OP_SHL_ARIT = 3'b100,
        OP_SHR_ARIT = 3'b101,
        OP_RESERVED = 3'b110,
        OP_SHR_LOGC = 3'b111
    } shop_e;

    // Status byte layout, most significant field first.
    typedef struct packed {
        logic sign;
        logic zero;
        logic gap5;
        logic half;
        logic gap3;
        logic parity;
        logic subtr;
        logic carry;
    } status_t;

    // Even parity via a reduction loop: 1 when the number of ones is even.
    function automatic logic even_ones(input logic [DW-1:0] v);
        logic acc;
        acc = 1'b1;
        for (int i = 0; i < DW; i++) begin
            acc = acc ^ v[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/bsu_shifter.sv
module bsu_shifter
    import bsu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0]   src,
    input  logic           cin,
    input  logic [OPW-1:0] code,
    output logic [W-1:0]   dst,
    output logic           cout,
    output logic           bad
);

    localparam int MSB = W - 1;

    shop_e  op;
    logic   fill_lo;   // bit entering position 0 on a left move
    logic   fill_hi;   // bit entering position MSB on a right move
    logic   go_left;
    logic [W-1:0] left_v;
    logic [W-1:0] right_v;

    assign op = shop_e'(code);

    // Per-operation choice of direction and fill bit.
    always_comb begin
        go_left = 1'b0;
        fill_lo = 1'b0;
        fill_hi = 1'b0;
        bad     = 1'b0;
        case (op)
            OP_ROL_CIRC: begin go_left = 1'b1; fill_lo = src[MSB]; end
            OP_ROL_CARY: begin go_left = 1'b1; fill_lo = cin;      end
            OP_SHL_ARIT: begin go_left = 1'b1; fill_lo = 1'b0;     end
            OP_ROR_CIRC: fill_hi = src[0];
            OP_ROR_CARY: fill_hi = cin;
            OP_SHR_ARIT: fill_hi = src[MSB];
            OP_SHR_LOGC: fill_hi = 1'b0;
            default:     bad = 1'b1;
        endcase
    end

    // Bit-sliced movers: every position takes its neighbour.
    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == 0) begin : g_lo
            assign left_v[i]  = fill_lo;
            assign right_v[i] = src[i+1];
        end else if (i == MSB) begin : g_hi
            assign left_v[i]  = src[i-1];
            assign right_v[i] = fill_hi;
        end else begin : g_mid
            assign left_v[i]  = src[i-1];
            assign right_v[i] = src[i+1];
        end
    end

    always_comb begin
        if (bad) begin
            dst  = src;
            cout = cin;
        end else if (go_left) begin
            dst  = left_v;
            cout = src[MSB];
        end else begin
            dst  = right_v;
            cout = src[0];
        end
    end

endmodule

// File: rtl/bsu_flags.sv
module bsu_flags
    import bsu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0]      val,
    input  logic              cy,
    output logic [FLAG_W-1:0] stat
);

    status_t s;

    always_comb begin
        s        = '0;
        s.sign   = val[W-1];
        s.zero   = (val == '0);
        s.parity = even_ones(val);
        s.carry  = cy;
        // half, subtr and the gap bits stay cleared
    end

    assign stat = s;

endmodule

// File: rtl/bsu_outreg.sv
module bsu_outreg
    import bsu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [W-1:0]      d_res,
    input  logic [FLAG_W-1:0] d_flg,
    input  logic              d_bad,
    output logic              q_vld,
    output logic [W-1:0]      q_res,
    output logic [FLAG_W-1:0] q_flg,
    output logic              q_bad
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
            q_res <= '0;
            q_flg <= '0;
            q_bad <= 1'b0;
        end else begin
            q_vld <= load;
            if (load) begin
                q_res <= d_res;
                q_flg <= d_flg;
                q_bad <= d_bad;
            end
        end
    end

endmodule

// File: rtl/byte_shift_unit.sv
module byte_shift_unit
    import bsu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [W-1:0]      operand,
    input  logic              carry_in,
    input  logic [OPW-1:0]    op_sel,
    output logic              out_valid,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] flags,
    output logic              illegal_op
);

    logic [W-1:0]      sh_res;
    logic              sh_cy;
    logic              sh_bad;
    logic [FLAG_W-1:0] sh_flg;

    bsu_shifter #(.W(W)) u_shift (
        .src  (operand),
        .cin  (carry_in),
        .code (op_sel),
        .dst  (sh_res),
        .cout (sh_cy),
        .bad  (sh_bad)
    );

    bsu_flags #(.W(W)) u_flags (
        .val  (sh_res),
        .cy   (sh_cy),
        .stat (sh_flg)
    );

    bsu_outreg #(.W(W)) u_oreg (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .d_res (sh_res),
        .d_flg (sh_flg),
        .d_bad (sh_bad),
        .q_vld (out_valid),
        .q_res (result),
        .q_flg (flags),
        .q_bad (illegal_op)
    );

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
    import bsu_pkg::*;
#(
    parameter int W = DW
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [W-1:0]      operand,
    input logic              carry_in,
    input logic [OPW-1:0]    op_sel,
    input logic              out_valid,
    input logic [W-1:0]      result,
    input logic [FLAG_W-1:0] flags,
    input logic              illegal_op
);

    assert_rot_left_circ_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b000) |=>
            (result == {$past(operand[W-2:0]), $past(operand[W-1])}
             && flags[0] == $past(operand[W-1]) && !illegal_op));

    assert_rot_right_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b011) |=>
            (result == {$past(carry_in), $past(operand[W-1:1])}
             && flags[0] == $past(operand[0])));

    assert_shr_logic_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b111) |=> (result[W-1] == 1'b0));

    assert_sign_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[7] == result[W-1]));

    assert_zero_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[6] == (result == '0)));

    assert_parity_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[2] == ($countones(result) % 2 == 0)));

    assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (rst)
        (flags[5] == 1'b0 && flags[4] == 1'b0 && flags[3] == 1'b0 && flags[1] == 1'b0));

    assert_illegal_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b110) |=>
            (illegal_op && result == $past(operand) && flags[0] == $past(carry_in)));

    assert_latency_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flags) && $stable(illegal_op)));

endmodule

bind byte_shift_unit bsu_checker #(.W(W)) u_chk (.*);

// File: tb/test_byte_shift_unit.sv
`timescale 1ns/1ps
module test_byte_shift_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] operand;
    logic       carry_in;
    logic [2:0] op_sel;
    logic       out_valid;
    logic [7:0] result;
    logic [7:0] flags;
    logic       illegal_op;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    byte_shift_unit i_byte_shift_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .operand    (operand),
        .carry_in   (carry_in),
        .op_sel     (op_sel),
        .out_valid  (out_valid),
        .result     (result),
        .flags      (flags),
        .illegal_op (illegal_op)
    );

    // Reference: returns {illegal, carry, result}
    function automatic logic [9:0] ref_op(input logic [2:0] op, input logic [7:0] a, input logic ci);
        logic [7:0] r;
        logic       c;
        logic       il;
        il = 1'b0;
        case (op)
            3'd0: begin r = (a << 1) | (a >> 7);       c = a[7]; end
            3'd1: begin r = (a >> 1) | (a << 7);       c = a[0]; end
            3'd2: begin r = (a << 1) | {7'b0, ci};     c = a[7]; end
            3'd3: begin r = (a >> 1) | {ci, 7'b0};     c = a[0]; end
            3'd4: begin r = a << 1;                    c = a[7]; end
            3'd5: begin r = (a >> 1) | (a & 8'h80);    c = a[0]; end
            3'd7: begin r = a >> 1;                    c = a[0]; end
            default: begin r = a; c = ci; il = 1'b1;   end
        endcase
        return {il, c, r};
    endfunction

    function automatic logic [7:0] ref_flags(input logic [7:0] r, input logic c);
        logic p;
        p = ($countones(r) % 2) == 0;
        return {r[7], (r == 8'h00), 1'b0, 1'b0, 1'b0, p, 1'b0, c};
    endfunction

    task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic ci);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op;
        operand  = a;
        carry_in = ci;
        @(negedge clk);
    endtask

    // R13: reset clears all outputs even with an active strobe
    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; operand = 8'hA5; carry_in = 1'b1; op_sel = 3'd6;
        repeat (3) @(negedge clk);
        check({out_valid, illegal_op, flags, result} == '0, "R13 reset",
              {out_valid, illegal_op, flags, result}, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Exhaustive sweep of one code over every operand and carry-in
    task automatic t_sweep(input logic [2:0] op, input string req);
        for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a < 256; a++) begin
                logic [9:0]  e;
                logic [17:0] exp_v;
                logic [17:0] act_v;
                e = ref_op(op, 8'(a), 1'(ci));
                apply(op, 8'(a), 1'(ci));
                exp_v = {e[9], 1'b1, ref_flags(e[7:0], e[8]), e[7:0]};
                act_v = {illegal_op, out_valid, flags, result};
                check(act_v == exp_v, req, act_v, exp_v);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Flag corner cases: zero result with carry out, sign, parity, fixed bits
    task automatic t_flag_corners();
        apply(3'd7, 8'h01, 1'b0);    // -> 00, Z=1, P=1, C=1
        check(flags == 8'h45 && result == 8'h00, "R8 R9 zero result", {2'b0, flags, result}, {2'b0, 8'h45, 8'h00});
        apply(3'd3, 8'h00, 1'b1);    // -> 80, S=1, P=0, C=0
        check(flags == 8'h80 && result == 8'h80, "R8 R9 sign", {2'b0, flags, result}, {2'b0, 8'h80, 8'h80});
        apply(3'd5, 8'hFF, 1'b0);    // -> FF, S=1, P=1, C=1
        check(flags == 8'h85 && result == 8'hFF, "R6 R10 all ones", {2'b0, flags, result}, {2'b0, 8'h85, 8'hFF});
        apply(3'd4, 8'h80, 1'b1);    // -> 00, Z, P, C
        check(flags == 8'h45 && result == 8'h00, "R5 R10 shift out", {2'b0, flags, result}, {2'b0, 8'h45, 8'h00});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // R12: outputs hold while in_valid is low
    task automatic t_hold();
        apply(3'd0, 8'h81, 1'b0);    // -> 03, C=1, P=1
        @(negedge clk);
        in_valid = 1'b0;
        operand  = 8'h55; op_sel = 3'd6; carry_in = 1'b1;
        check(out_valid == 1'b1 && result == 8'h03, "R12 latency", {9'b0, out_valid, result}, {9'b0, 1'b1, 8'h03});
        repeat (3) @(negedge clk);
        check({out_valid, illegal_op, flags, result} == {1'b0, 1'b0, 8'h05, 8'h03}, "R12 hold",
              {out_valid, illegal_op, flags, result}, {1'b0, 1'b0, 8'h05, 8'h03});
        // illegal code with strobe: R11
        apply(3'd6, 8'h3C, 1'b1);
        in_valid = 1'b0;
        check({illegal_op, flags, result} == {1'b1, 8'h05, 8'h3C}, "R11 passthrough",
              {1'b0, illegal_op, flags, result}, {1'b0, 1'b1, 8'h05, 8'h3C});
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_sweep(3'd0, "R1");
        t_sweep(3'd1, "R2");
        t_sweep(3'd2, "R3");
        t_sweep(3'd3, "R4");
        t_sweep(3'd4, "R5");
        t_sweep(3'd5, "R6");
        t_sweep(3'd7, "R7");
        t_sweep(3'd6, "R11");
        t_flag_corners();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule